// File: doc/BRIEF.md
# Legacy Shadow and SMRAM Memory Decoder

This block sits in a host bridge and decides, for every memory access below and around the first megabyte, whether the access is claimed by system DRAM or forwarded to the PCI bus. It holds the byte-wide configuration registers that steer the decision. Seven attribute bytes give each of thirteen shadow regions a two-bit field that routes reads and writes independently. One control byte governs the 128 KB legacy video/system-management window at 0xA0000–0xBFFFF.

Firmware uses the attribute fields to copy option and boot ROM images into DRAM and run them from there. It reads from PCI while writing to DRAM, then switches reads to DRAM and locks writes out. The window control lets normal cycles see either the video aperture on PCI or the hidden DRAM behind it. A separate enable gives system-management cycles the DRAM view regardless.

The decode is combinational from the register contents. A configuration write that lands on one clock edge steers the access presented in the very next cycle. A read-only byte reports the installed memory size.

Top module: `shadow_dec_top`

## Requirements
- R1: After reset the seven attribute bytes (offsets 0x59–0x5F) read 0x00 and the window control byte (offset 0x72) reads 0x02.
- R2: A configuration write to 0x59–0x5F or 0x72 stores all eight data bits, which read back at the same offset. Reads of any offset without a register return 0x00, and writes there change nothing that can be read.
- R3: Offset 0x57 reads the memory size in 8 MB units, computed from parameter RAM_MB and saturating at 255. Writes to 0x57 do not change it.
- R4: Addresses 0xF0000–0xFFFFF form region 0. Its field is bits 5:4 of the byte at 0x59.
- R5: Region i (1..12) covers 16 KB starting at 0xC0000 + (i−1)·0x4000. Its field sits in the byte at 0x59 + ceil(i/2). Odd i use bits 1:0 of that byte and even i use bits 5:4.
- R6: In a region field, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. A clear bit sends that direction to PCI. The field applies alike to normal and system-management cycles.
- R7: For a normal cycle in 0xA0000–0xBFFFF, the target is DRAM when bit 6 (open) of byte 0x72 is set and PCI when it is clear, for both directions.
- R8: For a system-management cycle in 0xA0000–0xBFFFF, the target is DRAM when bit 3 (enable) of byte 0x72 is set. Otherwise the cycle follows the R7 rule.
- R9: Addresses below 0xA0000 always target DRAM. Addresses at or above 0x100000 always target PCI.
- R10: A configuration write steers the access presented in the cycle after the write edge.
- R11: With a request valid, exactly one of the DRAM and PCI target outputs is high. With no request, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data for cfgAddr (combinational) |
| reqValid | input | 1 | Memory access present |
| reqAddr | input | ADDR_W | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSmm | input | 1 | 1 = system-management cycle |
| tgtDram | output | 1 | Access claimed by DRAM |
| tgtPci | output | 1 | Access forwarded to PCI |

## Verification
The bench builds the block with RAM_MB = 4096, which exceeds the 255-unit ceiling of the size byte. This makes the saturating branch of the size computation observable at offset 0x57, a branch the default size never reaches. ADDR_W stays at 32, so addresses far above the first megabyte can be driven to exercise the upper PCI default. Every region receives all four field codes under both directions and both cycle classes, with the neighbouring nibble holding the complement. A swapped nibble or an off-by-one byte index therefore changes a result.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;
  localparam int NUM_ATTR    = 7;
  localparam int NUM_REGIONS = 13;
  localparam logic [7:0] ATTR_BASE_OFS = 8'h59;
  localparam logic [7:0] WIN_CTRL_OFS  = 8'h72;
  localparam logic [7:0] MEMSZ_OFS     = 8'h57;
  localparam logic [7:0] WIN_CTRL_RST  = 8'h02;
  localparam int OPEN_BIT   = 6;
  localparam int SMMEN_BIT  = 3;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_ATTR  = 2'd1,
    RD_WIN   = 2'd2,
    RD_MEMSZ = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [NUM_ATTR-1:0] attrWe;
    logic                winWe;
    rdSel_e              rdSel;
    logic [2:0]          attrIdx;
  } cfgCtrl_t;
endpackage

// File: rtl/shadow_dec_ctrl.sv
module shadow_dec_ctrl
  import shadow_dec_pkg::*;
(
  input  logic       cfgWe,
  input  logic [7:0] cfgAddr,
  output cfgCtrl_t   ctrl
);
  logic [7:0] relOfs;
  logic       inAttr;

  assign relOfs = cfgAddr - ATTR_BASE_OFS;
  assign inAttr = (cfgAddr >= ATTR_BASE_OFS) &&
                  (cfgAddr < ATTR_BASE_OFS + 8'(NUM_ATTR));

  always_comb begin
    ctrl = '0;
    ctrl.attrIdx = relOfs[2:0];
    for (int i = 0; i < NUM_ATTR; i++) begin
      ctrl.attrWe[i] = cfgWe && inAttr && (relOfs == 8'(i));
    end
    ctrl.winWe = cfgWe && (cfgAddr == WIN_CTRL_OFS);
    if (inAttr)                     ctrl.rdSel = RD_ATTR;
    else if (cfgAddr == WIN_CTRL_OFS) ctrl.rdSel = RD_WIN;
    else if (cfgAddr == MEMSZ_OFS)  ctrl.rdSel = RD_MEMSZ;
    else                            ctrl.rdSel = RD_NONE;
  end

  // R2: at most one register strobe per write
  always_comb begin
    if (!$isunknown({cfgWe, cfgAddr})) begin
      assert_single_strobe_R2: assert ($onehot0({ctrl.attrWe, ctrl.winWe}));
    end
  end
endmodule

// File: rtl/shadow_dec_dp.sv
module shadow_dec_dp
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RAM_MB = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgCtrl_t          ctrl,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSmm,
  output logic              tgtDram,
  output logic              tgtPci
);
  localparam int MEM_UNITS = RAM_MB / 8;
  localparam logic [7:0] MEMSZ_VAL = (MEM_UNITS > 255) ? 8'd255 : 8'(MEM_UNITS);
  localparam longint EXP_BASE  = 64'h0C0000;
  localparam longint EXP_SIZE  = 64'h4000;
  localparam longint BIOS_BASE = 64'h0F0000;
  localparam longint BIOS_SIZE = 64'h10000;
  localparam longint WIN_LO    = 64'h0A0000;
  localparam longint WIN_HI    = 64'h0C0000;
  localparam longint TOP_1M    = 64'h100000;

  logic [7:0] attrReg [NUM_ATTR];
  logic [7:0] winReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ATTR; i++) attrReg[i] <= 8'h00;
      winReg <= WIN_CTRL_RST;
    end else begin
      for (int i = 0; i < NUM_ATTR; i++) begin
        if (ctrl.attrWe[i]) attrReg[i] <= cfgWrData;
      end
      if (ctrl.winWe) winReg <= cfgWrData;
    end
  end

  always_comb begin
    unique case (ctrl.rdSel)
      RD_ATTR:  cfgRdData = attrReg[ctrl.attrIdx];
      RD_WIN:   cfgRdData = winReg;
      RD_MEMSZ: cfgRdData = MEMSZ_VAL;
      default:  cfgRdData = 8'h00;
    endcase
  end

  logic [NUM_REGIONS-1:0] regHit;
  logic [1:0]             regField [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam longint RBASE   = (r == 0) ? BIOS_BASE : EXP_BASE + longint'(r - 1) * EXP_SIZE;
    localparam longint RSIZE   = (r == 0) ? BIOS_SIZE : EXP_SIZE;
    localparam int     BYTE_IX = (r + 1) / 2;
    localparam bit     HI_NIB  = (r == 0) || (r % 2 == 0);
    assign regHit[r]   = (reqAddr >= ADDR_W'(RBASE)) && (reqAddr < ADDR_W'(RBASE + RSIZE));
    if (HI_NIB) begin : g_hi
      assign regField[r] = attrReg[BYTE_IX][5:4];
    end else begin : g_lo
      assign regField[r] = attrReg[BYTE_IX][1:0];
    end
  end

  logic lowHit, winHit, toDram;
  assign lowHit = reqAddr < ADDR_W'(WIN_LO);
  assign winHit = (reqAddr >= ADDR_W'(WIN_LO)) && (reqAddr < ADDR_W'(WIN_HI));

  always_comb begin
    toDram = 1'b0;
    if (lowHit) begin
      toDram = 1'b1;
    end else if (winHit) begin
      toDram = winReg[OPEN_BIT] || (reqSmm && winReg[SMMEN_BIT]);
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (regHit[r]) toDram = reqWrite ? regField[r][1] : regField[r][0];
      end
    end
  end

  assign tgtDram = reqValid && toDram;
  assign tgtPci  = reqValid && !toDram;

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (tgtDram != tgtPci));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!tgtDram && !tgtPci));
  assert_low_dram_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr < ADDR_W'(WIN_LO)) |-> tgtDram);
  assert_high_pci_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= ADDR_W'(TOP_1M)) |-> tgtPci);
  assert_win_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.winWe |=> $stable(winReg));
  assert_win_reset_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (winReg == WIN_CTRL_RST));
endmodule

// File: rtl/shadow_dec_top.sv
module shadow_dec_top
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RAM_MB = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSmm,
  output logic              tgtDram,
  output logic              tgtPci
);
  cfgCtrl_t ctrl;

  shadow_dec_ctrl u_ctrl (
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .ctrl    (ctrl)
  );

  shadow_dec_dp #(.ADDR_W(ADDR_W), .RAM_MB(RAM_MB)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqSmm    (reqSmm),
    .tgtDram   (tgtDram),
    .tgtPci    (tgtPci)
  );
endmodule

// File: tb/tb_shadow_dec_top.sv
module tb_shadow_dec_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = 32'h0;
  logic        reqWrite = 1'b0;
  logic        reqSmm = 1'b0;
  logic        tgtDram, tgtPci;

  int checks = 0;
  int fails  = 0;
  int mdl [256];

  always #5 clk = ~clk;

  shadow_dec_top #(.ADDR_W(32), .RAM_MB(4096)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSmm(reqSmm),
    .tgtDram(tgtDram), .tgtPci(tgtPci)
  );

  function automatic bit refDram(longint a, bit wr, bit smm);
    int r, b, nib;
    if (a < 'hA0000) return 1'b1;
    if (a < 'hC0000) return mdl['h72][6] || (smm && mdl['h72][3]);
    if (a >= 'h100000) return 1'b0;
    if (a >= 'hF0000) r = 0;
    else r = int'((a - 'hC0000) / 'h4000) + 1;
    b = mdl['h59 + (r + 1) / 2];
    nib = (r == 0 || r % 2 == 0) ? (b >> 4) : b;
    return wr ? nib[1] : nib[0];
  endfunction

  task automatic step(bit we, int a, int d, bit v, longint addr, bit wr, bit smm, string tag);
    bit expD;
    @(negedge clk);
    cfgWe = we; cfgAddr = 8'(a); cfgWrData = 8'(d);
    reqValid = v; reqAddr = 32'(addr); reqWrite = wr; reqSmm = smm;
    #1;
    checks++;
    if (cfgRdData !== 8'(mdl[a])) begin
      fails++;
      $display("FAIL %s rd@%h got=%h exp=%h", tag, a, cfgRdData, 8'(mdl[a]));
    end
    expD = v && refDram(addr, wr, smm);
    checks++;
    if (tgtDram !== expD || tgtPci !== (v && !expD)) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0d smm=%0d got dram/pci=%b%b exp=%b%b",
               tag, addr, wr, smm, tgtDram, tgtPci, expD, v && !expD);
    end
    @(posedge clk);
    if (we && ((a >= 'h59 && a <= 'h5F) || a == 'h72)) mdl[a] = d;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 0;
    mdl['h72] = 2;
    mdl['h57] = 255;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset values
    for (int a = 'h59; a <= 'h5F; a++) step(0, a, 0, 0, 0, 0, 0, "R1");
    step(0, 'h72, 0, 0, 0, 0, 0, "R1");
    // R3: saturated size, writes ignored
    step(0, 'h57, 0, 0, 0, 0, 0, "R3");
    step(1, 'h57, 'h12, 0, 0, 0, 0, "R3");
    step(0, 'h57, 0, 0, 0, 0, 0, "R3");
    // R2: full-byte storage, unmapped offsets
    for (int a = 'h59; a <= 'h5F; a++) step(1, a, 'hA5 ^ a, 0, 0, 0, 0, "R2");
    for (int a = 'h59; a <= 'h5F; a++) step(0, a, 0, 0, 0, 0, 0, "R2");
    step(1, 'h58, 'hFF, 0, 0, 0, 0, "R2");
    step(0, 'h58, 0, 0, 0, 0, 0, "R2");
    step(1, 'h60, 'hFF, 0, 0, 0, 0, "R2");
    step(0, 'h60, 0, 0, 0, 0, 0, "R2");
    step(1, 'h72, 'hFF, 0, 0, 0, 0, "R2");
    step(0, 'h72, 0, 0, 0, 0, 0, "R2");
    step(1, 'h72, 'h02, 0, 0, 0, 0, "R2");

    // R4 R5 R6 R10: every region, every code, directions and classes
    for (int r = 0; r < 13; r++) begin
      for (int code = 0; code < 4; code++) begin
        int ofs, byteVal;
        longint rb, rs;
        bit hi;
        ofs = 'h59 + (r + 1) / 2;
        hi = (r == 0) || (r % 2 == 0);
        byteVal = hi ? ((code << 4) | (~code & 3)) : (((~code & 3) << 4) | code);
        rb = (r == 0) ? 'hF0000 : 'hC0000 + (r - 1) * 'h4000;
        rs = (r == 0) ? 'h10000 : 'h4000;
        step(1, ofs, byteVal, 0, 0, 0, 0, "R5");
        step(0, ofs, 0, 1, rb, 0, 0, "R10");
        step(0, ofs, 0, 1, rb, 1, 0, (r == 0) ? "R4" : "R5");
        step(0, ofs, 0, 1, rb + rs - 1, 0, 1, "R6");
        step(0, ofs, 0, 1, rb + rs - 1, 1, 1, "R6");
      end
    end

    // R7 R8: window control combinations
    for (int c = 0; c < 4; c++) begin
      int val;
      val = 'h02 | ((c & 1) << 6) | ((c >> 1) << 3);
      step(1, 'h72, val, 0, 0, 0, 0, "R10");
      for (int k = 0; k < 4; k++) begin
        step(0, 'h72, 0, 1, 'hA0000, k[0], k[1], k[1] ? "R8" : "R7");
        step(0, 'h72, 0, 1, 'hBFFFF, k[0], k[1], k[1] ? "R8" : "R7");
      end
    end

    // R9: fixed ranges
    step(0, 0, 0, 1, 'h9FFFF, 0, 0, "R9");
    step(0, 0, 0, 1, 'h0, 1, 1, "R9");
    step(0, 0, 0, 1, 'h100000, 0, 0, "R9");
    step(0, 0, 0, 1, 'h12345678, 1, 1, "R9");
    // R11: idle request
    step(0, 0, 0, 0, 'h0, 0, 0, "R11");
    step(0, 0, 0, 0, 'hA0000, 1, 1, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule